// File: doc/BRIEF.md
# Dual-Link Host Register Port

This block lets an external microcontroller read and write a small bank of 8-bit registers. It can use an 8-bit parallel bus or a four-wire SPI link. A strap input picks the link. Both links use the same data and strobe pins, so the pad ring outside the block turns the shared data pins into separate input, output and output-enable vectors.

Host pins are asynchronous to the block. They pass through a synchronizer before any edge is decoded. In parallel mode, a write is two strobes: first an address byte, then a data byte. Reads are combinational on the latched address and appear while the read strobe is low.

In serial mode, each SPI frame is three bytes: a command byte, an address byte and a data byte. The link runs in SPI mode 0.

Besides the general registers, the bank holds:
- a write-one-to-clear event status register;
- its interrupt enable mask, which drives an active-low interrupt;
- a sleep control register;
- a stream port, where every write pushes one byte into a FIFO that the internal datapath drains.

After reset the block is asleep. Any falling edge of chip select wakes it.

Top module: `dual_link_regif`

## Requirements
- R1: With `mode_serial`=1, parallel strobes write nothing, and `data_oe` is 8'h02 rather than 8'hFF while `cs_n` and `rd_n` are both low. With `mode_serial`=0 the parallel link is used.
- R2: In parallel mode, a rising `wr_n` while `cs_n` is low does one of two things. If `addr_sel` is 1, it latches `data_i` as the register address. If `addr_sel` is 0, it writes `data_i` into the register at the latched address.
- R3: In parallel mode, `data_oe` is 8'hFF only while `cs_n`=0 and `rd_n`=0, and is 8'h00 otherwise. While it is driven, `data_o` holds the addressed register.
- R4: In serial mode, data bit 2 is SCLK, bit 0 is MOSI and bit 1 is MISO, with `cs_n` as chip select. A frame is a command byte (bit 7: 1 = read, 0 = write), then the address byte, then the data byte, MSB first, with data sampled on rising SCLK.
- R5: In a serial read, the third byte returns the addressed register on `data_o[1]`, MSB first. `data_oe` is 8'h02 while `cs_n` is low.
- R6: After reset, the general registers, the status, the enable mask and the FIFO are all zero. `irq_n` is 1 and `asleep` is 1.
- R7: A high bit of `evt_i` sets the matching bit of the status register at 8'h10. `irq_n` is 0 while status AND the enable register at 8'h11 is nonzero. Writing 1 to a status bit clears that bit.
- R8: `asleep` clears on a falling edge of `cs_n`. Writing 1 to bit 0 of the control register at 8'h13 sets `asleep`, and reading that register returns the flag in bit 0.
- R9: Each write to the stream port at 8'h12 pushes the byte into a FIFO. `stream_data` and `stream_valid` present the oldest byte, and `stream_pop` removes it. Reading 8'h12 returns the FIFO fill count.
- R10: A stream write to a full FIFO is dropped. The count and the stored bytes stay unchanged.
- R11: General registers sit at addresses 0 to NREG-1. Other unmapped addresses read as 0, and writes to them change nothing.
- R12: In serial mode, SPI frames are ignored while `wr_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| mode_serial | input | 1 | Link strap: 0 parallel, 1 SPI |
| cs_n | input | 1 | Chip select, both links |
| wr_n | input | 1 | Parallel write strobe / SPI enable (low) |
| rd_n | input | 1 | Parallel read strobe |
| addr_sel | input | 1 | Parallel address (1) / data (0) select |
| data_i | input | 8 | Shared data pins, input side |
| data_o | output | 8 | Shared data pins, output side |
| data_oe | output | 8 | Per-pin output enable |
| irq_n | output | 1 | Active-low interrupt |
| asleep | output | 1 | Sleep flag |
| evt_i | input | 8 | Event pulses that set status bits |
| stream_pop | input | 1 | Remove oldest stream byte |
| stream_valid | output | 1 | Stream FIFO not empty |
| stream_data | output | 8 | Oldest stream byte |

## Verification
The assertions check the pin-driver rules on every cycle, in both modes. They also check that:
- the interrupt releases once a write-one-to-clear removes the last enabled status bit;
- sleep is left only through a chip-select falling edge;
- a push into a full FIFO leaves its count unchanged.

The bench scenarios are needed for the behaviour that spans whole transactions:
- the two-phase parallel address/data write, and the three-byte SPI frame decode with its MSB-first read-back;
- stream ordering, unmapped-address behaviour, and the rejection of SPI traffic without the enable and of parallel strobes in serial mode.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  localparam logic [7:0] A_STAT = 8'h10;
  localparam logic [7:0] A_IEN  = 8'h11;
  localparam logic [7:0] A_STRM = 8'h12;
  localparam logic [7:0] A_CTRL = 8'h13;
  localparam int unsigned SPI_FRAME_BITS = 24;

  typedef struct packed {
    logic       en;
    logic [7:0] addr;
    logic [7:0] data;
  } wr_req_t;

  function automatic logic [7:0] next_status(input logic [7:0] cur,
                                             input logic [7:0] set,
                                             input logic [7:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [7:0] spi_byte(input logic [6:0] prior, input logic b);
    return {prior, b};
  endfunction
endpackage

// File: rtl/dlr_sync.sv
module dlr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dlr_fifo.sv
module dlr_fifo #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic          valid,
  output logic          full,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign count   = wp - rp;
  assign full    = (count == FULL_CNT);
  assign valid   = (count != '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && valid;
  assign head    = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_ok) begin
        mem[wp[AW-1:0]] <= push_data;
        wp <= wp + 1'b1;
      end
      if (pop_ok) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/dlr_spi.sv
module dlr_spi
  import dlr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       mosi,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output wr_req_t    wr_req,
  output logic       miso
);
  localparam logic [4:0] LAST_BIT  = 5'(SPI_FRAME_BITS - 1);
  localparam logic [4:0] CMD_BIT   = 5'd7;
  localparam logic [4:0] ADDR_BIT  = 5'd15;
  localparam logic [4:0] DATA_BASE = 5'd16;

  logic [4:0] bitcnt;
  logic [6:0] rx;
  logic [7:0] tx;
  logic       cmd_rd, ld_pend;
  logic       frame_open;

  assign frame_open = (bitcnt <= LAST_BIT);
  assign miso       = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt  <= '0;
      rx      <= '0;
      tx      <= '0;
      cmd_rd  <= 1'b0;
      ld_pend <= 1'b0;
      rd_addr <= '0;
      wr_req  <= '0;
    end else begin
      wr_req.en <= 1'b0;
      ld_pend   <= 1'b0;
      if (!active) begin
        bitcnt <= '0;
      end else begin
        if (ld_pend) tx <= rd_data;
        if (sclk_rise && frame_open) begin
          rx     <= {rx[5:0], mosi};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == CMD_BIT) cmd_rd <= rx[6];
          if (bitcnt == ADDR_BIT) begin
            rd_addr <= spi_byte(rx, mosi);
            ld_pend <= cmd_rd;
          end
          if (bitcnt == LAST_BIT && !cmd_rd)
            wr_req <= '{en: 1'b1, addr: rd_addr, data: spi_byte(rx, mosi)};
        end
        if (sclk_fall && bitcnt > DATA_BASE) tx <= {tx[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/dlr_regbank.sv
module dlr_regbank
  import dlr_pkg::*;
#(
  parameter int unsigned NREG  = 8,
  parameter int unsigned CNT_W = 3,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_req_t          wr,
  input  logic [7:0]       rd_addr_a,
  input  logic [7:0]       rd_addr_b,
  input  logic [7:0]       evt_i,
  input  logic             cs_fall,
  input  logic [CNT_W-1:0] fifo_count,
  output logic [7:0]       rd_data_a,
  output logic [7:0]       rd_data_b,
  output logic             irq_n,
  output logic             asleep,
  output logic             strm_push,
  output logic [7:0]       stat_q,
  output logic [7:0]       ien_q
);
  logic [7:0]      gen_q [NREG];
  logic [NREG-1:0] hit;
  logic [7:0]      clr;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = wr.en && (wr.addr == 8'(g));
  end

  assign clr       = (wr.en && wr.addr == A_STAT) ? wr.data : 8'h00;
  assign strm_push = wr.en && (wr.addr == A_STRM);
  assign irq_n     = ~|(stat_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) gen_q[i] <= '0;
      stat_q <= '0;
      ien_q  <= '0;
      asleep <= 1'b1;
    end else begin
      for (int i = 0; i < NREG; i++) if (hit[i]) gen_q[i] <= wr.data;
      stat_q <= next_status(stat_q, evt_i, clr);
      if (wr.en && wr.addr == A_IEN) ien_q <= wr.data;
      if (wr.en && wr.addr == A_CTRL && wr.data[0]) asleep <= 1'b1;
      else if (cs_fall) asleep <= 1'b0;
    end
  end

  function automatic logic [7:0] read_reg(input logic [7:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a < 8'(NREG)) v = gen_q[a[IDX_W-1:0]];
    else begin
      case (a)
        A_STAT:  v = stat_q;
        A_IEN:   v = ien_q;
        A_STRM:  v = 8'(fifo_count);
        A_CTRL:  v = {7'b0, asleep};
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

  assign rd_data_a = read_reg(rd_addr_a);
  assign rd_data_b = read_reg(rd_addr_b);
endmodule

// File: rtl/dual_link_regif.sv
module dual_link_regif
  import dlr_pkg::*;
#(
  parameter int unsigned NREG        = 8,
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH) + 1,
  localparam int unsigned PIN_W      = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_serial,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       addr_sel,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic [7:0] data_oe,
  output logic       irq_n,
  output logic       asleep,
  input  logic [7:0] evt_i,
  input  logic       stream_pop,
  output logic       stream_valid,
  output logic [7:0] stream_data
);
  logic [PIN_W-1:0] pins_s;
  logic             s_cs, s_wr, s_asel;
  logic [7:0]       s_data;
  logic             cs_p, wr_p, sclk_p;
  logic             cs_fall, par_wr_edge, sclk_rise, sclk_fall, spi_active;
  logic [7:0]       paddr;
  wr_req_t          par_req, spi_req, wr_req;
  logic [7:0]       spi_addr, rd_a, rd_b;
  logic             miso, push_w, fifo_full_w;
  logic [CNT_W-1:0] fifo_count_w;
  logic [7:0]       fifo_cnt8, stat_w, ien_w;

  dlr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST({1'b1, 1'b1, 1'b0, 8'h00})) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, wr_n, addr_sel, data_i}), .q(pins_s));

  assign {s_cs, s_wr, s_asel, s_data} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p   <= 1'b1;
      wr_p   <= 1'b1;
      sclk_p <= 1'b0;
    end else begin
      cs_p   <= s_cs;
      wr_p   <= s_wr;
      sclk_p <= s_data[2];
    end
  end

  assign cs_fall     = cs_p & ~s_cs;
  assign par_wr_edge = ~mode_serial & ~s_cs & s_wr & ~wr_p;
  assign sclk_rise   = s_data[2] & ~sclk_p;
  assign sclk_fall   = ~s_data[2] & sclk_p;
  assign spi_active  = mode_serial & ~s_cs & ~s_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr   <= '0;
      par_req <= '0;
    end else begin
      par_req.en <= 1'b0;
      if (par_wr_edge) begin
        if (s_asel) paddr <= s_data;
        else par_req <= '{en: 1'b1, addr: paddr, data: s_data};
      end
    end
  end

  dlr_spi u_spi (
    .clk(clk), .rst_n(rst_n), .active(spi_active),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(s_data[0]),
    .rd_data(rd_b), .rd_addr(spi_addr), .wr_req(spi_req), .miso(miso));

  assign wr_req = mode_serial ? spi_req : par_req;

  dlr_regbank #(.NREG(NREG), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr_req), .rd_addr_a(paddr), .rd_addr_b(spi_addr),
    .evt_i(evt_i), .cs_fall(cs_fall), .fifo_count(fifo_count_w),
    .rd_data_a(rd_a), .rd_data_b(rd_b), .irq_n(irq_n), .asleep(asleep),
    .strm_push(push_w), .stat_q(stat_w), .ien_q(ien_w));

  dlr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_w), .push_data(wr_req.data),
    .pop(stream_pop), .head(stream_data), .valid(stream_valid),
    .full(fifo_full_w), .count(fifo_count_w));

  assign fifo_cnt8 = 8'(fifo_count_w);

  always_comb begin
    if (mode_serial) begin
      data_oe = {6'b0, ~cs_n, 1'b0};
      data_o  = {6'b0, miso, 1'b0};
    end else begin
      data_oe = {8{~cs_n & ~rd_n}};
      data_o  = rd_a;
    end
  end
endmodule

// File: rtl/dual_link_regif_chk.sv
module dual_link_regif_chk
  import dlr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       mode_serial,
  input logic       cs_n,
  input logic       rd_n,
  input logic [7:0] data_oe,
  input logic       irq_n,
  input logic       asleep,
  input logic [7:0] evt_i,
  input logic       stream_pop,
  input logic       cs_fall,
  input wr_req_t    wr_req,
  input logic [7:0] stat_w,
  input logic [7:0] ien_w,
  input logic       push_w,
  input logic       fifo_full_w,
  input logic [7:0] fifo_cnt8
);
  // R3: parallel drivers only during a selected read
  p_par_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_serial && data_oe != 8'h00) |-> (!cs_n && !rd_n));

  // R5: serial mode drives only the MISO pin, only while selected
  p_ser_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_serial && data_oe != 8'h00) |-> (data_oe == 8'h02 && !cs_n));

  // R7: clearing every enabled pending bit releases the interrupt
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req.en && wr_req.addr == A_STAT && ((stat_w & ien_w) & ~wr_req.data) == 8'h00
     && evt_i == 8'h00) |=> irq_n);

  // R8: a chip-select fall wakes the block
  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !asleep);

  // R8: sleep persists until a chip-select fall
  p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !cs_fall) |=> asleep);

  // R10: push into a full FIFO is dropped
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full_w && push_w && !stream_pop) |=> $stable(fifo_cnt8));
endmodule

bind dual_link_regif dual_link_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial), .cs_n(cs_n), .rd_n(rd_n),
  .data_oe(data_oe), .irq_n(irq_n), .asleep(asleep), .evt_i(evt_i),
  .stream_pop(stream_pop), .cs_fall(cs_fall), .wr_req(wr_req), .stat_w(stat_w),
  .ien_w(ien_w), .push_w(push_w), .fifo_full_w(fifo_full_w), .fifo_cnt8(fifo_cnt8));

// File: tb/dual_link_regif_bench.sv
module dual_link_regif_bench;
  localparam int NREG = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_serial = 1'b0, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, addr_sel = 1'b0;
  logic [7:0] pdata = 8'h00, evt_i = 8'h00;
  logic sclk = 1'b0, mosi = 1'b0, stream_pop = 1'b0;
  logic [7:0] data_i, data_o, data_oe, stream_data;
  logic irq_n, asleep, stream_valid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign data_i = mode_serial ? {5'b0, sclk, 1'b0, mosi} : pdata;

  dual_link_regif #(.NREG(NREG), .FIFO_DEPTH(DEPTH)) u_dual_link_regif (
    .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial), .cs_n(cs_n), .wr_n(wr_n),
    .rd_n(rd_n), .addr_sel(addr_sel), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .irq_n(irq_n), .asleep(asleep), .evt_i(evt_i),
    .stream_pop(stream_pop), .stream_valid(stream_valid), .stream_data(stream_data));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic par_write(input logic a0, input logic [7:0] d);
    cs_n = 1'b0; addr_sel = a0; pdata = d; wait_n(4);
    wr_n = 1'b0; wait_n(4);
    wr_n = 1'b1; wait_n(4);
    cs_n = 1'b1; wait_n(4);
  endtask

  task automatic par_reg_write(input logic [7:0] a, input logic [7:0] d);
    par_write(1'b1, a);
    par_write(1'b0, d);
  endtask

  task automatic par_read(input logic [7:0] a, output logic [7:0] d, output logic [7:0] oe);
    par_write(1'b1, a);
    cs_n = 1'b0; wait_n(4);
    rd_n = 1'b0; wait_n(2);
    d = data_o; oe = data_oe;
    rd_n = 1'b1; cs_n = 1'b1; wait_n(4);
  endtask

  task automatic spi_xfer(input logic [7:0] cmd, input logic [7:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output logic [7:0] oe);
    logic [23:0] frame;
    frame = {cmd, a, d};
    rd = 8'h00;
    cs_n = 1'b0; wait_n(6);
    oe = data_oe;
    for (int k = 0; k < 24; k++) begin
      mosi = frame[23-k]; wait_n(6);
      if (k >= 16) rd[23-k] = data_o[1];
      sclk = 1'b1; wait_n(6);
      sclk = 1'b0;
    end
    wait_n(6); cs_n = 1'b1; wait_n(6);
  endtask

  function automatic logic [7:0] pval(input int a);
    return 8'(a * 37 + 5);
  endfunction

  function automatic logic [7:0] sval(input int a);
    return 8'(a * 53 + 11) ^ 8'h5A;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, oe;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R6 reset state
    chk("R6 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R6 asleep", {7'b0, asleep}, 8'h01);
    chk("R6 stream_valid", {7'b0, stream_valid}, 8'h00);
    chk("R3 oe idle", data_oe, 8'h00);
    par_read(8'h05, rd, oe);
    chk("R6 reg5 reset", rd, 8'h00);
    chk("R8 woken by cs", {7'b0, asleep}, 8'h00);

    // R2/R3 parallel sweep of general registers
    for (int a = 0; a < NREG; a++) par_reg_write(8'(a), pval(a));
    for (int a = 0; a < NREG; a++) begin
      par_read(8'(a), rd, oe);
      chk("R2 parallel readback", rd, pval(a));
      chk("R3 oe during read", oe, 8'hFF);
    end
    cs_n = 1'b0; wait_n(3);
    chk("R3 oe cs low rd high", data_oe, 8'h00);
    cs_n = 1'b1; rd_n = 1'b0; wait_n(3);
    chk("R3 oe cs high rd low", data_oe, 8'h00);
    rd_n = 1'b1; wait_n(2);

    // R11 unmapped
    par_reg_write(8'h20, 8'hEE);
    par_read(8'h20, rd, oe);
    chk("R11 unmapped read", rd, 8'h00);
    par_read(8'h00, rd, oe);
    chk("R11 reg0 intact", rd, pval(0));

    // R7 status and interrupt
    par_reg_write(8'h11, 8'h05);
    @(negedge clk); evt_i = 8'h06; @(negedge clk); evt_i = 8'h00; wait_n(1);
    chk("R7 irq asserted", {7'b0, irq_n}, 8'h00);
    par_read(8'h10, rd, oe);
    chk("R7 status", rd, 8'h06);
    par_reg_write(8'h10, 8'h04);
    chk("R7 irq released", {7'b0, irq_n}, 8'h01);
    par_read(8'h10, rd, oe);
    chk("R7 status after clear", rd, 8'h02);
    @(negedge clk); evt_i = 8'h02; @(negedge clk); evt_i = 8'h00; wait_n(1);
    chk("R7 masked event", {7'b0, irq_n}, 8'h01);

    // R8 sleep
    par_reg_write(8'h13, 8'h01);
    chk("R8 sleep set", {7'b0, asleep}, 8'h01);
    par_read(8'h13, rd, oe);
    chk("R8 ctrl read after wake", rd, 8'h00);
    chk("R8 awake", {7'b0, asleep}, 8'h00);

    // R9 stream ordering and count
    for (int i = 0; i < 3; i++) par_reg_write(8'h12, 8'(8'hA1 + i));
    par_read(8'h12, rd, oe);
    chk("R9 count", rd, 8'h03);
    for (int i = 0; i < 3; i++) begin
      chk("R9 stream order", stream_data, 8'(8'hA1 + i));
      stream_pop = 1'b1; @(negedge clk); stream_pop = 1'b0;
    end
    chk("R9 drained", {7'b0, stream_valid}, 8'h00);
    // R10 overflow
    for (int i = 0; i < DEPTH + 2; i++) par_reg_write(8'h12, 8'(8'hB0 + i));
    par_read(8'h12, rd, oe);
    chk("R10 count saturates", rd, 8'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      chk("R10 kept bytes", stream_data, 8'(8'hB0 + i));
      stream_pop = 1'b1; @(negedge clk); stream_pop = 1'b0;
    end
    chk("R10 extra dropped", {7'b0, stream_valid}, 8'h00);

    // R4/R5 serial sweep
    mode_serial = 1'b1; wr_n = 1'b0; wait_n(6);
    for (int a = 0; a < NREG; a++) spi_xfer(8'h00, 8'(a), sval(a), rd, oe);
    for (int a = 0; a < NREG; a++) begin
      spi_xfer(8'h80, 8'(a), 8'h00, rd, oe);
      chk("R4 spi readback", rd, sval(a));
      chk("R5 spi oe", oe, 8'h02);
    end
    spi_xfer(8'h80, 8'h10, 8'h00, rd, oe);
    chk("R5 spi status read", rd, 8'h02);

    // R12 enable high ignores frame
    wr_n = 1'b1; wait_n(4);
    spi_xfer(8'h00, 8'h03, 8'h99, rd, oe);
    wr_n = 1'b0; wait_n(4);
    spi_xfer(8'h80, 8'h03, 8'h00, rd, oe);
    chk("R12 ignored frame", rd, sval(3));

    // R1 parallel strobes ignored in serial mode
    par_reg_write(8'h04, 8'h77);
    wr_n = 1'b0; wait_n(4);
    spi_xfer(8'h80, 8'h04, 8'h00, rd, oe);
    chk("R1 parallel write ignored", rd, sval(4));
    cs_n = 1'b0; rd_n = 1'b0; wait_n(3);
    chk("R1 serial oe", data_oe, 8'h02);
    cs_n = 1'b1; rd_n = 1'b1; wait_n(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule